// File: doc/BRIEF.md
# Overlapped Windowed Register File

This block is a register file of 74 physical words that the datapath sees as 32 logical registers. A two-bit current-window pointer picks which slice of the file the logical numbers 10 to 31 reach. Logical 0 to 9 always reach the same ten global words. The other 64 words form a ring of four windows, A to D. Each window holds ten private locals and shares a six-word group with each of its two ring neighbours.

A call pulse moves the pointer forward one window and a return pulse moves it back. What the caller wrote into its upper six registers is therefore what the callee finds in its lower six, and nothing is copied. A nesting depth counter refuses a call when three calls are already outstanding, and it refuses a return when none is outstanding. Each refusal raises a one-cycle status flag.

There are two combinational read ports and one write port that is written on the clock edge. All three are addressed with 5-bit logical numbers.

Top module: `winreg_file`

## Requirements
- R1: After reset every logical register reads 0, `cwp` is 0 (window A), and `ovf` and `unf` are 0.
- R2: Logical numbers 0 to 9 select physical words 0 to 9 whatever the value of `cwp`.
- R3: A logical number n from 10 to 31 selects physical word 10 + ((n - 10 + 16*cwp) mod 64). With cwp 0 to 3 for windows A to D, this gives A = 10..31, B = 26..47, C = 42..63, and D = 58..73 followed by 10..15.
- R4: The upper six logical registers (26 to 31) of window k are the same storage as the lower six (10 to 15) of window k+1 mod 4, so window D's upper six are window A's lower six.
- R5: A write with `we`=1 updates the addressed word at the rising edge, using the `cwp` in force before any call or return in that cycle. A read of that word in the same cycle returns the old value.
- R6: With `call_i`=1, `ret_i`=0 and fewer than three outstanding calls, `cwp` becomes cwp+1 mod 4 after the edge and the depth rises by one.
- R7: With `ret_i`=1, `call_i`=0 and at least one outstanding call, `cwp` becomes cwp-1 mod 4 after the edge and the depth falls by one.
- R8: A call made with three outstanding calls leaves `cwp` and the depth unchanged and drives `ovf` high for exactly the following cycle.
- R9: A return made with no outstanding call leaves `cwp` unchanged and drives `unf` high for exactly the following cycle.
- R10: `call_i` and `ret_i` both high in the same cycle change neither the pointer nor the depth, and raise no flag.
- R11: Call and return pulses applied while `rst_n` is low are ignored, so `cwp` is 0 when reset releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Advance to the next window |
| ret_i | input | 1 | Go back to the previous window |
| ra_addr | input | 5 | Read port A logical number |
| ra_data | output | 32 | Read port A data |
| rb_addr | input | 5 | Read port B logical number |
| rb_data | output | 32 | Read port B data |
| we | input | 1 | Write enable |
| wa_addr | input | 5 | Write logical number |
| wd | input | 32 | Write data |
| cwp | output | 2 | Current window pointer |
| ovf | output | 1 | Refused-call flag, one cycle |
| unf | output | 1 | Refused-return flag, one cycle |

## Verification
Seeded random traffic mixes writes, reads, calls and returns. A bench model maps every logical number through the window formula and so separates globals from windowed words and each window from its neighbours. Directed sequences cover the following cases:
- A parameter handed from caller to callee, and from D back across the ring into A, which exposes a wrong overlap direction or a wrong wrap.
- Four calls in a row and a return at depth zero, which separate refusal from a silent wrap of the pointer.
- Simultaneous call and return.
- Pulses held during reset.
- A write and a read of the same word in one cycle, which separates write-then-read from read-then-write behaviour.

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter int DW    = 32,
  parameter int NGLOB = 10,
  parameter int NLOC  = 10,
  parameter int NOVL  = 6,
  parameter int NWIN  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic [4:0]    ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [4:0]    rb_addr,
  output logic [DW-1:0] rb_data,
  input  logic          we,
  input  logic [4:0]    wa_addr,
  input  logic [DW-1:0] wd,
  output logic [1:0]    cwp,
  output logic          ovf,
  output logic          unf
);
  localparam int SPAN   = NLOC + NOVL;
  localparam int RING   = SPAN * NWIN;
  localparam int NPHYS  = RING + NGLOB;
  localparam int PW     = $clog2(NPHYS);
  localparam int DEPMAX = NWIN - 1;

  logic [DW-1:0] regs [NPHYS];
  logic [1:0]    depth;
  logic [PW-1:0] pa, pb, pw;

  function automatic logic [PW-1:0] xlate(input logic [4:0] l, input logic [1:0] w);
    int off;
    if (32'(l) < NGLOB) return PW'(l);
    off = (int'(l) - NGLOB + SPAN * int'(w)) % RING;
    return PW'(NGLOB + off);
  endfunction

  assign pa = xlate(ra_addr, cwp);
  assign pb = xlate(rb_addr, cwp);
  assign pw = xlate(wa_addr, cwp);
  assign ra_data = regs[pa];
  assign rb_data = regs[pb];

  wire do_call = call_i & ~ret_i;
  wire do_ret  = ret_i & ~call_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) regs[i] <= '0;
      cwp   <= '0;
      depth <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else begin
      if (we) regs[pw] <= wd;
      ovf <= 1'b0;
      unf <= 1'b0;
      if (do_call) begin
        if (depth == 2'(DEPMAX)) ovf <= 1'b1;
        else begin
          cwp   <= cwp + 2'd1;
          depth <= depth + 2'd1;
        end
      end else if (do_ret) begin
        if (depth == 2'd0) unf <= 1'b1;
        else begin
          cwp   <= cwp - 2'd1;
          depth <= depth - 2'd1;
        end
      end
    end
  end

  // R8: refused call holds the pointer and raises ovf
  a_r8_overflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (do_call && depth == 2'(DEPMAX)) |=> (ovf && cwp == $past(cwp)));
  // R9: refused return holds the pointer and raises unf
  a_r9_underflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (do_ret && depth == 2'd0) |=> (unf && cwp == $past(cwp)));
  // R6: accepted call advances by one
  a_r6_call_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (do_call && depth != 2'(DEPMAX)) |=> (cwp == $past(cwp) + 2'd1 && !ovf));
  // R7: accepted return steps back by one
  a_r7_ret_back: assert property (@(posedge clk) disable iff (!rst_n)
    (do_ret && depth != 2'd0) |=> (cwp == $past(cwp) - 2'd1 && !unf));
  // R10: simultaneous pulses change nothing
  a_r10_both_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i) |=> ($stable(cwp) && !ovf && !unf));
  // R5: write lands in the word chosen by the old pointer
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs[$past(pw)] == $past(wd));
  // R8/R9: never both flags
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));
endmodule

// File: tb/tb_winreg_file.sv
module tb_winreg_file;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call_i = 1'b0, ret_i = 1'b0, we = 1'b0;
  logic [4:0]  ra_addr = '0, rb_addr = '0, wa_addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] ra_data, rb_data;
  logic [1:0]  cwp;
  logic        ovf, unf;

  int checks = 0, fails = 0;
  logic [31:0] mem [74];
  int m_cwp = 0, m_dep = 0;
  bit m_ovf = 0, m_unf = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  winreg_file dut (.clk, .rst_n, .call_i, .ret_i, .ra_addr, .ra_data,
    .rb_addr, .rb_data, .we, .wa_addr, .wd, .cwp, .ovf, .unf);

  function automatic int phys(input int l, input int w);
    if (l < 10) return l;
    return 10 + ((l - 10 + 16 * w) % 64);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (time %0t)", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 74; i++) mem[i] = '0;
    m_cwp = 0; m_dep = 0; m_ovf = 0; m_unf = 0;
  endtask

  task automatic step(input bit c, input bit r, input bit w, input int wa,
                      input logic [31:0] d, input int a, input int b);
    @(negedge clk);
    call_i = c; ret_i = r; we = w; wa_addr = 5'(wa); wd = d;
    ra_addr = 5'(a); rb_addr = 5'(b);
    #1;
    chk(a < 10 ? "R2 read A" : "R3 read A", ra_data, mem[phys(a, m_cwp)]);
    chk(b < 10 ? "R2 read B" : "R3 read B", rb_data, mem[phys(b, m_cwp)]);
    chk("R6/R7 cwp", 32'(cwp), 32'(m_cwp));
    chk("R8 ovf", 32'(ovf), 32'(m_ovf));
    chk("R9 unf", 32'(unf), 32'(m_unf));
    @(posedge clk);
    if (w) mem[phys(wa, m_cwp)] = d;
    m_ovf = 0; m_unf = 0;
    if (c && !r) begin
      if (m_dep == 3) m_ovf = 1; else begin m_cwp = (m_cwp + 1) % 4; m_dep++; end
    end else if (r && !c) begin
      if (m_dep == 0) m_unf = 1; else begin m_cwp = (m_cwp + 3) % 4; m_dep--; end
    end
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    void'($urandom(32'h5eed1));
    model_reset();
    // R11: pulses during reset are ignored
    call_i = 1'b1;
    repeat (3) @(posedge clk);
    ret_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    call_i = 1'b0; ret_i = 1'b0;
    rst_n = 1'b1;
    #1 chk("R11 cwp after reset", 32'(cwp), 32'd0);
    // R1: reset state of all logical registers
    for (int i = 0; i < 32; i += 2) step(0, 0, 0, 0, 0, i, i + 1);
    // R4: caller upper six become callee lower six, then around D into A
    step(0, 0, 1, 26, 32'hA0A0_0026, 26, 10);
    step(1, 0, 1, 31, 32'hB0B0_0031, 10, 31);
    step(0, 0, 0, 0, 0, 10, 15);
    step(1, 0, 1, 26, 32'hC1C1_0026, 10, 26);
    step(1, 0, 1, 26, 32'hD2D2_0026, 10, 26);
    step(0, 0, 1, 26, 32'hDDDD_0026, 10, 26);
    // R8: fourth call refused
    step(1, 0, 0, 0, 0, 26, 16);
    step(1, 0, 0, 0, 0, 26, 16);
    idle();
    // R10: both pulses together
    step(1, 1, 0, 0, 0, 0, 0);
    idle();
    // R5: same-cycle write and read, write uses pre-return window
    step(0, 1, 1, 20, 32'h5555_0020, 20, 20);
    step(0, 0, 0, 0, 0, 20, 26);
    step(0, 1, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 10, 26);
    // R9: return at depth zero refused
    step(0, 1, 0, 0, 0, 10, 26);
    idle();
    step(0, 0, 0, 0, 0, 10, 15);
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      int rc = $urandom_range(0, 99);
      step(rc < 18, rc >= 80, $urandom_range(0, 1) == 1, $urandom_range(0, 31),
           $urandom, $urandom_range(0, 31), $urandom_range(0, 31));
    end
    // R1: reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1 model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 32; i += 2) step(0, 0, 0, 0, 0, i, i + 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule